// File: doc/BRIEF.md
# Double-Buffer Audio DMA Address Engine

This block generates byte addresses for a playback DMA stream that alternates between two memory buffers. Software programs a 32-bit base address and a 16-bit length for each buffer, chooses the sample format, and sets a run bit. Each sample-frame request then yields one byte address. The address advances by the frame size that the format implies. When the offset inside the active buffer reaches that buffer's length, the engine moves to the other buffer at offset zero. It also raises a finished flag for the buffer it has just left. Software clears the flag by writing it back.

Software reaches the block through a 16-bit register port with halfword offsets. The current position and the offset within the active buffer can be read back at any time. The bus master that fetches samples, the sample FIFO and the rate generator all sit outside the block. Only the frame request strobe enters.

Top module: `dbuf_dma_addr`

## Requirements
- R1: After reset, every register reads zero except two: the interrupt-type register at 0x02 reads 0x0001 and the format register at 0x16 reads 0x0010. irq and dma_addr_valid are low.
- R2: The halfword offsets are: control at 0x00, interrupt type at 0x02, buffer A base low/high at 0x04/0x06, buffer B base low/high at 0x08/0x0A, length A at 0x0C, length B at 0x0E, position low/high at 0x10/0x12, offset at 0x14 and format at 0x16. Only bits 5:0 of the control and format registers are stored. Bits 15:6 of those registers read as zero. Any other offset reads zero.
- R3: Interrupt-type bit 1 marks buffer A finished and bit 2 marks buffer B finished. Bits 15:5 read zero. Writing a 1 to a bit in 4:0 clears it, writing 0 leaves it unchanged, and writing 0xFFFF clears all of them. Software cannot set a bit.
- R4: Control bit 0 is the run bit. While it is clear, a frame request is ignored: no address strobe is produced, and the offset, active buffer and position do not change.
- R5: The frame size in bytes is 1 with format bits {5,4} = 00. It is 2 with 01 (16-bit) or 10 (two channels), and 4 with 11.
- R6: A frame request taken while running produces a one-cycle dma_addr_valid pulse in the next cycle. dma_addr then carries the position that held when the request was taken.
- R7: The position register always equals the active buffer's base plus the current offset. The offset can be read at 0x14, and both update one cycle after each frame request.
- R8: If offset plus frame size is at least the active buffer's length, the offset returns to 0 and the other buffer becomes active. A length of 0 therefore switches buffers on every frame. The finished bit for the buffer just left is set on the same clock edge.
- R9: irq is high exactly while interrupt-type bit 1 or bit 2 is set, and stays high until software acknowledges.
- R10: If a buffer finishes in the same cycle that software writes an acknowledge to that buffer's bit, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset (bit 0 ignored) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr, combinational |
| frame_req | input | 1 | One-cycle sample-frame request |
| dma_addr | output | 32 | Byte address of the frame just granted |
| dma_addr_valid | output | 1 | One-cycle strobe qualifying dma_addr |
| irq | output | 1 | Combined buffer-finished interrupt |

## Verification
Two events can land on the same clock edge. One is hardware setting a finished bit at a buffer switch. The other is a software write that acknowledges the interrupt-type register. The bench provokes this both directly and at random. In the directed case it steps the offset until the next frame will switch buffers, then issues that frame in the same cycle as a 0xFFFF acknowledge. It judges the result by reading back the interrupt-type register and checking that the new bit survived while the older bits were cleared. A behavioural model checks every cycle. It applies the engine step before the write and ORs in the set afterwards, so any ordering error in the design shows up as a mismatch on reg_rdata or irq.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 32;
  localparam int OFS_W  = 16;
  localparam int CFG_W  = 6;
  localparam int ACK_W  = 5;

  // word indices (byte offset >> 1)
  localparam logic [3:0] IX_CTL     = 4'd0;
  localparam logic [3:0] IX_IRQ     = 4'd1;
  localparam logic [3:0] IX_BASEA_L = 4'd2;
  localparam logic [3:0] IX_BASEA_H = 4'd3;
  localparam logic [3:0] IX_BASEB_L = 4'd4;
  localparam logic [3:0] IX_BASEB_H = 4'd5;
  localparam logic [3:0] IX_LENA    = 4'd6;
  localparam logic [3:0] IX_LENB    = 4'd7;
  localparam logic [3:0] IX_POS_L   = 4'd8;
  localparam logic [3:0] IX_POS_H   = 4'd9;
  localparam logic [3:0] IX_OFS     = 4'd10;
  localparam logic [3:0] IX_FMT     = 4'd11;

  localparam logic [ACK_W-1:0] IRQ_RESET = 5'b00001;
  localparam logic [CFG_W-1:0] FMT_RESET = 6'b010000;

  typedef struct packed {
    logic             wrap;
    logic [OFS_W-1:0] ofs;
  } adv_t;

  // bytes per frame from the format bits: wide samples and stereo each double it
  function automatic logic [2:0] frame_bytes(input logic [CFG_W-1:0] fmt);
    case ({fmt[5], fmt[4]})
      2'b00:   frame_bytes = 3'd1;
      2'b11:   frame_bytes = 3'd4;
      default: frame_bytes = 3'd2;
    endcase
  endfunction

  // next offset within a buffer, reporting when the buffer is used up
  function automatic adv_t advance(input logic [OFS_W-1:0] ofs,
                                   input logic [2:0]       step,
                                   input logic [OFS_W-1:0] len);
    logic [OFS_W:0] sum;
    sum          = {1'b0, ofs} + {{(OFS_W-2){1'b0}}, step};
    advance.wrap = (sum >= {1'b0, len});
    advance.ofs  = advance.wrap ? '0 : sum[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/dbuf_regs.sv
module dbuf_regs
  import dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic [1:0]        done_set,
  input  logic [ADDR_W-1:0] pos,
  input  logic [OFS_W-1:0]  ofs,
  output logic              run,
  output logic [ADDR_W-1:0] base_a,
  output logic [ADDR_W-1:0] base_b,
  output logic [OFS_W-1:0]  len_a,
  output logic [OFS_W-1:0]  len_b,
  output logic [CFG_W-1:0]  fmt,
  output logic [REG_W-1:0]  rdata,
  output logic              irq
);
  logic [CFG_W-1:0] ctl_q;
  logic [ACK_W-1:0] irq_q;
  logic [ACK_W-1:0] ack;
  logic [3:0]       idx;
  logic             unused_addr_lsb;

  assign idx             = addr[4:1];
  assign unused_addr_lsb = addr[0];
  assign ack = (wr_en && idx == IX_IRQ) ? wdata[ACK_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      fmt    <= FMT_RESET;
      base_a <= '0;
      base_b <= '0;
      len_a  <= '0;
      len_b  <= '0;
      irq_q  <= IRQ_RESET;
    end else begin
      if (wr_en) begin
        case (idx)
          IX_CTL:     ctl_q         <= wdata[CFG_W-1:0];
          IX_FMT:     fmt           <= wdata[CFG_W-1:0];
          IX_BASEA_L: base_a[15:0]  <= wdata;
          IX_BASEA_H: base_a[31:16] <= wdata;
          IX_BASEB_L: base_b[15:0]  <= wdata;
          IX_BASEB_H: base_b[31:16] <= wdata;
          IX_LENA:    len_a         <= wdata;
          IX_LENB:    len_b         <= wdata;
          default: ;
        endcase
      end
      // a buffer switch outranks an acknowledge arriving on the same edge
      irq_q <= (irq_q & ~ack) | {2'b00, done_set, 1'b0};
    end
  end

  assign run = ctl_q[0];
  assign irq = irq_q[1] | irq_q[2];

  always_comb begin
    case (idx)
      IX_CTL:     rdata = {{(REG_W-CFG_W){1'b0}}, ctl_q};
      IX_IRQ:     rdata = {{(REG_W-ACK_W){1'b0}}, irq_q};
      IX_BASEA_L: rdata = base_a[15:0];
      IX_BASEA_H: rdata = base_a[31:16];
      IX_BASEB_L: rdata = base_b[15:0];
      IX_BASEB_H: rdata = base_b[31:16];
      IX_LENA:    rdata = len_a;
      IX_LENB:    rdata = len_b;
      IX_POS_L:   rdata = pos[15:0];
      IX_POS_H:   rdata = pos[31:16];
      IX_OFS:     rdata = ofs;
      IX_FMT:     rdata = {{(REG_W-CFG_W){1'b0}}, fmt};
      default:    rdata = '0;
    endcase
  end

  assert_set_wins_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_set[0] |=> irq_q[1]);
  assert_set_wins_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_set[1] |=> irq_q[2]);
  assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ack[1] || ack[2])) |=> irq);
  assert_flag_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q[1]) |-> $past(done_set[0]));
endmodule

// File: rtl/dbuf_walker.sv
module dbuf_walker
  import dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              frame_req,
  input  logic [ADDR_W-1:0] base_a,
  input  logic [ADDR_W-1:0] base_b,
  input  logic [OFS_W-1:0]  len_a,
  input  logic [OFS_W-1:0]  len_b,
  input  logic [2:0]        step,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [ADDR_W-1:0] pos,
  output logic              wrap_evt,
  output logic              wrap_from_b,
  output logic [ADDR_W-1:0] dma_addr_q,
  output logic              addr_valid_q
);
  logic              area_q;     // 0: buffer A active, 1: buffer B active
  logic              frame_go;
  logic [OFS_W-1:0]  len_sel;
  logic [ADDR_W-1:0] base_sel;
  adv_t              adv;

  assign frame_go    = frame_req & run;
  assign len_sel     = area_q ? len_b  : len_a;
  assign base_sel    = area_q ? base_b : base_a;
  assign adv         = advance(ofs_q, step, len_sel);
  assign wrap_evt    = frame_go & adv.wrap;
  assign wrap_from_b = area_q;
  assign pos         = base_sel + {{(ADDR_W-OFS_W){1'b0}}, ofs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_q        <= '0;
      area_q       <= 1'b0;
      dma_addr_q   <= '0;
      addr_valid_q <= 1'b0;
    end else begin
      addr_valid_q <= frame_go;
      if (frame_go) begin
        dma_addr_q <= pos;
        ofs_q      <= adv.ofs;
        if (adv.wrap) area_q <= ~area_q;
      end
    end
  end

  assert_no_strobe_paused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_req && !run) |=> !addr_valid_q);
  assert_hold_paused_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(ofs_q) && $stable(area_q)));
  assert_wrap_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ((ofs_q == '0) && (area_q != $past(area_q))));
  assert_strobe_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid_q |-> (dma_addr_q == $past(pos)));
endmodule

// File: rtl/dbuf_dma_addr.sv
module dbuf_dma_addr
  import dbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        frame_req,
  output logic [31:0] dma_addr,
  output logic        dma_addr_valid,
  output logic        irq
);
  logic              run;
  logic [ADDR_W-1:0] base_a, base_b, pos;
  logic [OFS_W-1:0]  len_a, len_b, ofs;
  logic [CFG_W-1:0]  fmt;
  logic [2:0]        step;
  logic              wrap_evt, wrap_from_b;
  logic [1:0]        done_set;

  assign step     = frame_bytes(fmt);
  assign done_set = {wrap_evt & wrap_from_b, wrap_evt & ~wrap_from_b};

  dbuf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .done_set(done_set), .pos(pos), .ofs(ofs), .run(run),
    .base_a(base_a), .base_b(base_b), .len_a(len_a), .len_b(len_b),
    .fmt(fmt), .rdata(reg_rdata), .irq(irq)
  );

  dbuf_walker u_walker (
    .clk(clk), .rst_n(rst_n), .run(run), .frame_req(frame_req),
    .base_a(base_a), .base_b(base_b), .len_a(len_a), .len_b(len_b), .step(step),
    .ofs_q(ofs), .pos(pos), .wrap_evt(wrap_evt), .wrap_from_b(wrap_from_b),
    .dma_addr_q(dma_addr), .addr_valid_q(dma_addr_valid)
  );
endmodule

// File: tb/dbuf_dma_addr_bench.sv
module dbuf_dma_addr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        frame_req = 1'b0;
  logic [31:0] dma_addr;
  logic        dma_addr_valid;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_ctl, m_irq, m_fmt, m_la, m_lb;
  logic [31:0] m_ba, m_bb, m_addr;
  int          m_ofs;
  bit          m_area, m_valid;

  always #4 clk = ~clk;

  dbuf_dma_addr u_dbuf_dma_addr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_req(frame_req),
    .dma_addr(dma_addr), .dma_addr_valid(dma_addr_valid), .irq(irq)
  );

  function automatic int ref_bytes(input logic [15:0] f);
    int b = 1;
    if (f[4]) b = b * 2;
    if (f[5]) b = b * 2;
    return b;
  endfunction

  function automatic logic [31:0] ref_pos();
    return (m_area ? m_bb : m_ba) + 32'(m_ofs);
  endfunction

  function automatic logic [15:0] ref_read(input logic [4:0] a);
    logic [31:0] p = ref_pos();
    case (a & 5'h1E)
      5'h00: return m_ctl;
      5'h02: return m_irq;
      5'h04: return m_ba[15:0];
      5'h06: return m_ba[31:16];
      5'h08: return m_bb[15:0];
      5'h0A: return m_bb[31:16];
      5'h0C: return m_la;
      5'h0E: return m_lb;
      5'h10: return p[15:0];
      5'h12: return p[31:16];
      5'h14: return 16'(m_ofs);
      5'h16: return m_fmt;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 0; m_irq = 16'h0001; m_fmt = 16'h0010;
      m_ba = 0; m_bb = 0; m_la = 0; m_lb = 0;
      m_ofs = 0; m_area = 0; m_valid = 0; m_addr = 0;
    end else begin
      logic [15:0] setb;
      setb = 0;
      m_valid = 0;
      if (frame_req && m_ctl[0]) begin
        int nxt;
        m_addr  = ref_pos();
        m_valid = 1;
        nxt = m_ofs + ref_bytes(m_fmt);
        if (nxt >= int'(m_area ? m_lb : m_la)) begin
          setb   = m_area ? 16'h0004 : 16'h0002;
          m_area = !m_area;
          m_ofs  = 0;
        end else m_ofs = nxt;
      end
      if (reg_wr) begin
        case (reg_addr & 5'h1E)
          5'h00: m_ctl = reg_wdata & 16'h003F;
          5'h02: m_irq = m_irq & ~(reg_wdata & 16'h001F);
          5'h04: m_ba[15:0]  = reg_wdata;
          5'h06: m_ba[31:16] = reg_wdata;
          5'h08: m_bb[15:0]  = reg_wdata;
          5'h0A: m_bb[31:16] = reg_wdata;
          5'h0C: m_la = reg_wdata;
          5'h0E: m_lb = reg_wdata;
          5'h16: m_fmt = reg_wdata & 16'h003F;
          default: ;
        endcase
      end
      m_irq = m_irq | setb;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, sampled 6 ns after the rising edge
  initial forever begin
    @(posedge clk);
    #6;
    if (rst_n && !done) begin
      chk("R6 strobe", {31'b0, dma_addr_valid}, {31'b0, m_valid});
      if (m_valid) chk("R6 address", dma_addr, m_addr);
      chk("R9 irq", {31'b0, irq}, {31'b0, (m_irq[1] | m_irq[2])});
      chk("R7 readback", {16'b0, reg_rdata}, {16'b0, ref_read(reg_addr)});
    end
  end

  task automatic cyc(input bit w, input logic [4:0] a, input logic [15:0] d, input bit f);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; frame_req = f;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 16'h0000, 1'b1);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    cyc(1'b0, a, 16'h0000, 1'b0);
    #2;
    chk(tag, {16'b0, reg_rdata}, {16'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h00, 16'h0000, "R1 ctl");
    rd(5'h02, 16'h0001, "R1 irqtype");
    rd(5'h16, 16'h0010, "R1 format");
    rd(5'h10, 16'h0000, "R1 pos");
    rd(5'h0C, 16'h0000, "R1 len");
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 strobe", {31'b0, dma_addr_valid}, 32'd0);
    // R2 map and masks
    wr(5'h00, 16'hFFC2); rd(5'h00, 16'h0002, "R2 ctl mask");
    wr(5'h16, 16'hFFFF); rd(5'h16, 16'h003F, "R2 fmt mask");
    wr(5'h16, 16'h0000);
    wr(5'h04, 16'h0100); wr(5'h06, 16'h1000);
    wr(5'h08, 16'h0200); wr(5'h0A, 16'h2000);
    wr(5'h0C, 16'h0008); wr(5'h0E, 16'h0006);
    rd(5'h06, 16'h1000, "R2 base A high");
    rd(5'h0E, 16'h0006, "R2 len B");
    rd(5'h18, 16'h0000, "R2 unmapped");
    rd(5'h10, 16'h0100, "R7 pos low");
    rd(5'h12, 16'h1000, "R7 pos high");
    // R3 write-zero keeps, write-all clears
    wr(5'h02, 16'h0000); rd(5'h02, 16'h0001, "R3 zero write");
    wr(5'h02, 16'hFFFF); rd(5'h02, 16'h0000, "R3 clear all");
    // R4 paused
    wr(5'h00, 16'h0000);
    frames(3);
    rd(5'h14, 16'h0000, "R4 offset held");
    // run, step 1, buffer A length 8
    wr(5'h00, 16'h0001);
    frames(8);
    rd(5'h02, 16'h0002, "R8 A finished");
    chk("R9 irq high", {31'b0, irq}, 32'd1);
    rd(5'h10, 16'h0200, "R8 switched to B");
    rd(5'h12, 16'h2000, "R8 B high");
    rd(5'h14, 16'h0000, "R8 offset zero");
    frames(3);
    rd(5'h10, 16'h0203, "R7 pos in B");
    // R5 frame sizes
    wr(5'h16, 16'h0010); frames(1);
    rd(5'h14, 16'h0005, "R5 16-bit step");
    wr(5'h16, 16'h0030); frames(1);
    rd(5'h02, 16'h0006, "R8 B finished");
    wr(5'h16, 16'h0020); frames(2);
    rd(5'h10, 16'h0104, "R5 stereo step");
    // R3 acknowledge per bit, R9 drop
    wr(5'h02, 16'h0002); rd(5'h02, 16'h0004, "R3 ack A");
    chk("R9 irq still", {31'b0, irq}, 32'd1);
    wr(5'h02, 16'h0004); rd(5'h02, 16'h0000, "R3 ack B");
    chk("R9 irq low", {31'b0, irq}, 32'd0);
    // R10 finish and acknowledge on one edge
    frames(1);
    cyc(1'b1, 5'h02, 16'hFFFF, 1'b1);
    rd(5'h02, 16'h0002, "R10 set wins");
    // R4 pause mid-stream
    wr(5'h00, 16'h0000);
    frames(3);
    rd(5'h14, 16'h0000, "R4 offset held run");
    rd(5'h10, 16'h0200, "R4 pos held");
    wr(5'h02, 16'hFFFF);
    wr(5'h00, 16'h0001);
    // random mix, judged by the model every cycle
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom % 16);
      if (r == 10)      cyc(1'b1, 5'h02, 16'($urandom), 1'b0);
      else if (r == 11) cyc(1'b1, 5'h16, 16'($urandom), ($urandom % 2) == 0);
      else if (r == 12) cyc(1'b1, 5'h00, (($urandom % 4) == 0) ? 16'h0000 : 16'h0001, 1'b1);
      else if (r == 13) cyc(1'b1, (($urandom % 2) == 0) ? 5'h0C : 5'h0E, 16'($urandom % 13), 1'b1);
      else              cyc(1'b0, 5'(($urandom % 12) * 2), 16'h0000, r < 9);
    end
    cyc(1'b0, 5'h00, 16'h0000, 1'b0);
    repeat (2) @(posedge clk);
    #6;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule